// File: doc/BRIEF.md
# DMA Single-Transfer Channel Sequencer

This block carries out one service request for a DMA channel that an upstream arbiter has already selected. A one-cycle start strobe hands over a source and a destination address. The sequencer then runs a fixed-length startup, one read on a simple bus master interface, and one write of the word it read. A fixed-length shutdown closes the request. The ready input stretches the read and write data phases by inserting wait states. Apart from those wait states, the cycle count of a request is fixed, so software can work out the peak request rate directly from the slave wait states.

The controller is a five-state machine: `ST_IDLE`, `ST_ENTRY`, `ST_READ`, `ST_WRITE` and `ST_EXIT`. It has these transitions:
- accept: `ST_IDLE` to `ST_ENTRY` on start.
- entry_done: `ST_ENTRY` to `ST_READ` when the phase timer expires.
- read_ack: `ST_READ` to `ST_WRITE` when ready is sampled high.
- write_ack: `ST_WRITE` to `ST_EXIT` when ready is sampled high.
- exit_done: `ST_EXIT` to `ST_IDLE` when the phase timer expires.

A down-counting phase timer measures the entry and exit phases. A small register file holds the addresses and the word that was read. With zero wait states a request keeps the block busy for 9 cycles. An upstream two-cycle arbitration pipeline brings the cold-start latency of a software request to 11 cycles.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `busy_o`, `done_o`, `bus_rd_o` and `bus_wr_o` are all 0.
- R2: A start strobe sampled high while idle raises `busy_o` in the next cycle. `busy_o` is then high for exactly 4 entry cycles with no bus strobe before `bus_rd_o` first rises, so the first read cycle is busy cycle 5.
- R3: During the read phase, `bus_rd_o` is 1 and `bus_addr_o` equals the source address captured at start. The phase lasts 1 + N cycles, where N is the number of cycles in which `bus_ready_i` was sampled low during the phase.
- R4: During the write phase, `bus_wr_o` is 1, `bus_addr_o` equals the captured destination, and `bus_wdata_o` equals the `bus_rdata_i` value sampled in the read cycle that had ready high. The phase lasts 1 + M cycles, where M is the number of write wait states.
- R5: The exit phase lasts exactly 3 cycles after the last write cycle, with no bus strobe. `done_o` is high for exactly one cycle, which is the last busy cycle, and `busy_o` is 0 in the following cycle.
- R6: The total number of busy cycles per request is 4 + (1 + N) + (1 + M) + 3. For example, N = 1 and M = 3 give 13 cycles.
- R7: A start strobe sampled while `busy_o` is high is ignored. The addresses it carries are not used, and the running request keeps its length.
- R8: `bus_rd_o` and `bus_wr_o` are never high together, and neither is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Channel start strobe from the arbiter |
| src_addr_i | input | ADDR_W | Source address, captured with an accepted start |
| dst_addr_i | input | ADDR_W | Destination address, captured with an accepted start |
| busy_o | output | 1 | High from the first entry cycle through the last exit cycle |
| done_o | output | 1 | One-cycle pulse in the last exit cycle |
| bus_addr_o | output | ADDR_W | Bus address (source in the read phase, destination in the write phase) |
| bus_rd_o | output | 1 | Read strobe, high for the whole read data phase |
| bus_wr_o | output | 1 | Write strobe, high for the whole write data phase |
| bus_wdata_o | output | DATA_W | Write data (the word captured during the read) |
| bus_rdata_i | input | DATA_W | Read data, valid in the read cycle that has ready high |
| bus_ready_i | input | 1 | Slave ready; low inserts a wait state |

## Verification
The assertions check on every cycle the properties that hold at each clock edge:
- The strobes are exclusive and appear only while busy.
- A strobe and its address and data stay put across a wait state.
- `done_o` is followed by idle.
- The phase timer never exceeds its loaded length.

Exact phase lengths, the busy count of 9 + N + M, data forwarding from read to write, and rejection of a start during a request can only be shown by the bench scenarios. The bench walks a table of address, data and wait-state combinations and counts cycles at the ports.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ENTRY = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_EXIT  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/dma_phase_timer.sv
module dma_phase_timer #(
    parameter int MAX_LEN = 4,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R6: a loaded phase length never exceeds the longest fixed phase
    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= MAX_LEN - 1);
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int ENTRY_CYC = 4,
    parameter int EXIT_CYC  = 3,
    localparam int MAX_LEN  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC,
    localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ready_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             accept_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             rd_capture_o,
    output logic             busy_o,
    output logic             done_o
);
    seq_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)    state_d = ST_ENTRY;
            ST_ENTRY: if (tmr_zero_i) state_d = ST_READ;
            ST_READ:  if (ready_i)    state_d = ST_WRITE;
            ST_WRITE: if (ready_i)    state_d = ST_EXIT;
            ST_EXIT:  if (tmr_zero_i) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tmr_load_o   = 1'b0;
        tmr_val_o    = '0;
        accept_o     = 1'b0;
        rd_o         = 1'b0;
        wr_o         = 1'b0;
        rd_capture_o = 1'b0;
        busy_o       = 1'b1;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o     = 1'b0;
                accept_o   = start_i;
                tmr_load_o = start_i;
                tmr_val_o  = CNT_W'(ENTRY_CYC - 1);
            end
            ST_ENTRY: ;
            ST_READ: begin
                rd_o         = 1'b1;
                rd_capture_o = ready_i;
            end
            ST_WRITE: begin
                wr_o       = 1'b1;
                tmr_load_o = ready_i;
                tmr_val_o  = CNT_W'(EXIT_CYC - 1);
            end
            ST_EXIT: done_o = tmr_zero_i;
            default: busy_o = 1'b0;
        endcase
    end

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o) && ((rd_o || wr_o) -> busy_o));
    assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o && !ready_i |=> rd_o);
    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o && !ready_i |=> wr_o);
    assert_done_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    assert_entry_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && !rd_o && !wr_o);
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              sel_src_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (accept_i) begin
            src_q <= src_i;
            dst_q <= dst_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         data_q <= '0;
        else if (capture_i) data_q <= rdata_i;
    end

    assign addr_o  = sel_src_i ? src_q : dst_q;
    assign wdata_o = data_q;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ENTRY_CYC = 4,
    parameter int EXIT_CYC  = 3,
    localparam int MAX_LEN  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC,
    localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_addr_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ready_i
);
    logic             tmr_load, tmr_zero, accept, rd_capture;
    logic [CNT_W-1:0] tmr_val;

    dma_seq_ctrl #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ready_i     (bus_ready_i),
        .tmr_zero_i  (tmr_zero),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .accept_o    (accept),
        .rd_o        (bus_rd_o),
        .wr_o        (bus_wr_o),
        .rd_capture_o(rd_capture),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    dma_phase_timer #(.MAX_LEN(MAX_LEN)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .zero_o    (tmr_zero)
    );

    dma_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .src_i    (src_addr_i),
        .dst_i    (dst_addr_i),
        .capture_i(rd_capture),
        .rdata_i  (bus_rdata_i),
        .sel_src_i(bus_rd_o),
        .addr_o   (bus_addr_o),
        .wdata_o  (bus_wdata_o)
    );

    // R3: address is held across read wait states
    assert_rd_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_o && !bus_ready_i |=> $stable(bus_addr_o));
    // R4: address and data are held across write wait states
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_o && !bus_ready_i |=> $stable(bus_addr_o) && $stable(bus_wdata_o));
    // R7: a start during a request does not change the bus address
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && bus_rd_o && !bus_ready_i |=> $stable(bus_addr_o));
endmodule

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] data;
        logic [7:0]  rws;
        logic [7:0]  wws;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 32'h0000_2000, 32'hDEAD_BEEF, 8'd0, 8'd0},
        '{32'h0000_1004, 32'h0000_3000, 32'h1234_5678, 8'd1, 8'd3},
        '{32'hA000_0000, 32'h5000_0010, 32'hCAFE_F00D, 8'd2, 8'd1},
        '{32'h0000_0040, 32'hFFFF_FFFC, 32'h0000_0001, 8'd0, 8'd5},
        '{32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 8'd4, 8'd0},
        '{32'h1357_9BDF, 32'h2468_ACE0, 32'h5A5A_A5A5, 8'd7, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] src_addr_i = '0;
    logic [31:0] dst_addr_i = '0;
    logic        busy_o, done_o, bus_rd_o, bus_wr_o;
    logic [31:0] bus_addr_o, bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        bus_ready_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc_total = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_seq i_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
        .busy_o(busy_o), .done_o(done_o), .bus_addr_o(bus_addr_o),
        .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_wdata_o(bus_wdata_o),
        .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > WATCHDOG && !finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // one full request; poke issues a second start while busy (R7)
    task automatic run_xfer(input vec_t v, input bit poke);
        int cyc = 0, rd_n = 0, wr_n = 0, done_n = 0, done_at = 0;
        int first_rd = 0, last_wr = 0, addr_bad = 0, data_bad = 0, strobe_bad = 0;
        @(negedge clk);
        start_i = 1'b1; src_addr_i = v.src; dst_addr_i = v.dst;
        @(negedge clk);
        start_i = 1'b0; src_addr_i = ~v.src; dst_addr_i = ~v.dst;
        chk("R2 busy after start", longint'(busy_o), 1);
        while (busy_o && cyc < 200) begin
            cyc++;
            if (bus_rd_o && bus_wr_o) strobe_bad++;
            if (bus_rd_o) begin
                if (first_rd == 0) first_rd = cyc;
                if (bus_addr_o != v.src) addr_bad++;
                rd_n++;
                bus_ready_i = (rd_n == int'(v.rws) + 1);
                bus_rdata_i = bus_ready_i ? v.data : ~v.data;
            end else if (bus_wr_o) begin
                if (bus_addr_o != v.dst) addr_bad++;
                if (bus_wdata_o != v.data) data_bad++;
                wr_n++;
                last_wr = cyc;
                bus_ready_i = (wr_n == int'(v.wws) + 1);
            end else begin
                bus_ready_i = 1'b0;
            end
            if (done_o) begin done_n++; done_at = cyc; end
            if (poke) begin
                start_i = (cyc == 2 || cyc == 6);
                src_addr_i = 32'h0BAD_0000; dst_addr_i = 32'h0BAD_1111;
            end
            @(negedge clk);
        end
        start_i = 1'b0; bus_ready_i = 1'b0;
        if (!busy_o && (bus_rd_o || bus_wr_o)) strobe_bad++;
        chk("R2 first read at busy cycle 5", first_rd, 5);
        chk("R3 read phase length", rd_n, int'(v.rws) + 1);
        chk(poke ? "R7 address with start while busy" : "R3/R4 bus address", addr_bad, 0);
        chk("R4 write phase length", wr_n, int'(v.wws) + 1);
        chk("R4 write data forwarded", data_bad, 0);
        chk("R5 exit length", cyc - last_wr, 3);
        chk("R5 single done pulse", done_n, 1);
        chk("R5 done on last busy cycle", done_at, cyc);
        chk(poke ? "R7 length unchanged" : "R6 total busy cycles", cyc,
            9 + int'(v.rws) + int'(v.wws));
        chk("R8 strobe exclusivity", strobe_bad, 0);
        chk("R5 idle after done", longint'(busy_o | done_o), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", longint'(busy_o), 0);
        chk("R1 strobes in reset", longint'({done_o, bus_rd_o, bus_wr_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", longint'({busy_o, done_o, bus_rd_o, bus_wr_o}), 0);

        for (int i = 0; i < NVEC; i++) run_xfer(VECS[i], 1'b0);

        // R7: start strobes during a request are ignored
        run_xfer(VECS[1], 1'b1);

        // back-to-back requests
        run_xfer(VECS[2], 1'b0);
        run_xfer(VECS[0], 1'b0);

        // R1: reset in the middle of a read phase
        @(negedge clk);
        start_i = 1'b1; src_addr_i = 32'h10; dst_addr_i = 32'h20;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R3 read strobe in wait state", longint'(bus_rd_o), 1);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset clears busy", longint'({busy_o, bus_rd_o, bus_wr_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after mid-request reset", longint'({busy_o, done_o}), 0);
        run_xfer(VECS[3], 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule